// File: doc/BRIEF.md
# UART Status and Interrupt Logic

This block keeps the status word of a high-speed UART with transmit and receive FIFOs. The transmitter, the receiver, the FIFOs and the two active-low modem pins send it level and event inputs. Three event bits are sticky: receive idle timeout, autobaud done and CTS change. Each stays set until software writes 1 to it through a clear strobe and mask. The remaining bits are live copies of hardware levels. The transmit-holding-empty bit leads to one of two outputs. A 2-bit transfer mode chooses between an interrupt, gated by its enable, and a DMA request. The sticky bits, gated by their enables, also drive the interrupt.

A receive timeout counter is paced by a character-time tick supplied from outside. It is a three-state machine. WAIT_DATA is the state while the receive path is empty. It goes to COUNTING once data is present (transition *arm*). In COUNTING, a push or a pop of a character restarts the count (transition *restart*). If the receive path drains, the machine returns to WAIT_DATA (transition *drain*). When the count reaches the limit, the machine moves to EXPIRED and pulses the timeout event (transition *fire*). From EXPIRED, a push or pop goes back to COUNTING (transition *rearm*), and a drain goes back to WAIT_DATA (transition *drain*). The limit is WL*4+12 ticks, where WL = 5 + the 2-bit word-length code.

Status bit layout: 0 receive timeout, 1 autobaud done, 2 CTS event, 3 transmit holding empty, 4 transmitter idle, 5 transmit FIFO empty, 6 transmit FIFO full, 7 CTS asserted, 8 DSR asserted. All higher bits are reserved. The enable bits and the clear-mask bits use the same positions as the low status bits.

Top module: `uart_stat_irq`

## Requirements
- R1: After reset, status reads 0x0038 (bits 3, 4, 5 set) when pins are high, the holding buffer, shift register and transmit FIFO are empty and the FIFO is not full; irq and dma_req are 0.
- R2: With receive data present and untouched, status bit 0 sets on the clock edge that samples the (WL*4+12)-th unit_tick after arming, and not before; WL = 5 + cfg_word_len.
- R3: A push or pop restarts the timeout count to zero; while rx_has_data is 0 no timeout is ever raised.
- R4: Sticky bits 0..2 stay set until a cycle with clr_wr=1 and the matching clr_mask bit 1; a clear mask bit of 0 leaves them; a set event in the same cycle as a clear wins.
- R5: Status bits 7 and 8 are the inverse of cts_n and dsr_n, visible two clock edges after a pin change.
- R6: Every change of cts_n, in either direction, sets bit 2 exactly once, three clock edges after the change.
- R7: Bit 4 (transmitter idle) is 1 exactly when the transmit shift register is empty and the holding stage is empty (tx_hold_empty in non-FIFO mode, tx_fifo_empty in FIFO mode), one edge after the inputs.
- R8: Bit 3 sets when tx_fifo_level <= tx_fifo_trig (FIFO mode) or when tx_hold_empty is 1 (non-FIFO mode); tx_write clears it on the next edge and takes priority over the set.
- R9: irq is 1 when any of bits 0..2 is set together with its int_en bit, or when bit 3 and int_en[3] are set with mode 01; otherwise 0.
- R10: dma_req equals bit 3 when mode is 10 or 11 and is 0 for modes 00 and 01; in those DMA modes bit 3 does not raise irq.
- R11: Bits 5 and 6 follow tx_fifo_empty and tx_fifo_full one edge later.
- R12: Status bits 9 and above always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word_len | input | 2 | Word-length code, WL = 5 + code |
| cfg_fifo_mode | input | 1 | 1 selects FIFO mode |
| cfg_xfer_mode | input | 2 | 00 off, 01 interrupt, 10/11 DMA for bit 3 |
| int_en | input | 4 | Interrupt enables for status bits 0..3 |
| clr_wr | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 3 | Bits of the sticky field to clear |
| unit_tick | input | 1 | Character-time unit strobe |
| rx_has_data | input | 1 | Receive buffer or FIFO holds data |
| rx_push | input | 1 | A character was received |
| rx_pop | input | 1 | Receive data was read |
| autobaud_done | input | 1 | Autobaud detection finished pulse |
| cts_n | input | 1 | Active-low clear-to-send pin |
| dsr_n | input | 1 | Active-low data-set-ready pin |
| tx_hold_empty | input | 1 | Non-FIFO holding buffer empty |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| tx_fifo_full | input | 1 | Transmit FIFO full |
| tx_fifo_level | input | 5 | Transmit FIFO fill level |
| tx_fifo_trig | input | 5 | Transmit FIFO trigger level |
| tx_write | input | 1 | Transmit data written |
| status | output | 16 | Status word |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
Results appear at different delays. The transmit flags, bit 3 and the sticky set and clear all appear after one clock edge. The modem mirrors appear after two edges and the CTS event after three. The timeout appears on the edge that samples the limit-th tick, counted from the edge that armed the machine. irq and dma_req follow the status bits in the same cycle. The bench drives inputs and samples outputs on the falling edge. It advances a counted number of falling edges before each check, and it checks the timeout one tick before the limit as well as at it.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
    localparam int ST_RXTO   = 0;
    localparam int ST_ABD    = 1;
    localparam int ST_CTSEV  = 2;
    localparam int ST_THE    = 3;
    localparam int ST_TI     = 4;
    localparam int ST_TFE    = 5;
    localparam int ST_TFF    = 6;
    localparam int ST_CTS    = 7;
    localparam int ST_DSR    = 8;
    localparam int N_STICKY  = 3;
    localparam int N_EVT     = 4;
    localparam int USED_BITS = 9;

    typedef enum logic [1:0] {
        XM_OFF   = 2'b00,
        XM_IRQ   = 2'b01,
        XM_DMA_A = 2'b10,
        XM_DMA_B = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        TO_WAIT_DATA = 2'b00,
        TO_COUNTING  = 2'b01,
        TO_EXPIRED   = 2'b10
    } to_state_e;
endpackage

// File: rtl/uart_pin_sync.sv
module uart_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], pin_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout
    import uart_stat_pkg::*;
#(
    parameter int WL_CODE_W = 2,
    parameter int WL_BASE   = 5,
    parameter int TO_MUL    = 4,
    parameter int TO_ADD    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WL_CODE_W-1:0] word_len,
    input  logic                 unit_tick,
    input  logic                 rx_has_data,
    input  logic                 rx_push,
    input  logic                 rx_pop,
    output logic                 expire_o
);
    localparam int MAX_LIM = (WL_BASE + (1 << WL_CODE_W) - 1) * TO_MUL + TO_ADD;
    localparam int CNT_W   = $clog2(MAX_LIM + 1);

    to_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] limit;

    always_comb limit = CNT_W'((WL_BASE + int'(word_len)) * TO_MUL + TO_ADD);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TO_WAIT_DATA;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        expire_o = 1'b0;
        unique case (state_q)
            TO_WAIT_DATA: begin
                if (rx_has_data) begin            // arm
                    state_d = TO_COUNTING;
                    cnt_d   = '0;
                end
            end
            TO_COUNTING: begin
                if (!rx_has_data) begin           // drain
                    state_d = TO_WAIT_DATA;
                    cnt_d   = '0;
                end else if (rx_push || rx_pop) begin  // restart
                    cnt_d = '0;
                end else if (unit_tick) begin
                    if (cnt_q >= limit - CNT_W'(1)) begin  // fire
                        state_d  = TO_EXPIRED;
                        cnt_d    = '0;
                        expire_o = 1'b1;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            TO_EXPIRED: begin
                if (!rx_has_data) begin           // drain
                    state_d = TO_WAIT_DATA;
                end else if (rx_push || rx_pop) begin  // rearm
                    state_d = TO_COUNTING;
                    cnt_d   = '0;
                end
            end
            default: state_d = TO_WAIT_DATA;
        endcase
    end

    // R2: a timeout is only raised while receive data is present
    a_r2_expire_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> rx_has_data);

    // R3: an empty receive path always returns the machine to waiting
    a_r3_empty_waits: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_has_data |=> (state_q == TO_WAIT_DATA));

    // R3: a push or pop never raises a timeout in the same cycle
    a_r3_restart_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push || rx_pop) |-> !expire_o);
endmodule

// File: rtl/uart_stat_irq.sv
module uart_stat_irq
    import uart_stat_pkg::*;
#(
    parameter int STAT_W      = 16,
    parameter int LVL_W       = 5,
    parameter int SYNC_STAGES = 2,
    parameter int WL_BASE     = 5,
    parameter int TO_MUL      = 4,
    parameter int TO_ADD      = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_word_len,
    input  logic                cfg_fifo_mode,
    input  logic [1:0]          cfg_xfer_mode,
    input  logic [N_EVT-1:0]    int_en,
    input  logic                clr_wr,
    input  logic [N_STICKY-1:0] clr_mask,
    input  logic                unit_tick,
    input  logic                rx_has_data,
    input  logic                rx_push,
    input  logic                rx_pop,
    input  logic                autobaud_done,
    input  logic                cts_n,
    input  logic                dsr_n,
    input  logic                tx_hold_empty,
    input  logic                tx_shift_empty,
    input  logic                tx_fifo_empty,
    input  logic                tx_fifo_full,
    input  logic [LVL_W-1:0]    tx_fifo_level,
    input  logic [LVL_W-1:0]    tx_fifo_trig,
    input  logic                tx_write,
    output logic [STAT_W-1:0]   status,
    output logic                irq,
    output logic                dma_req
);
    logic                cts_sync, dsr_sync, cts_prev_q, cts_change;
    logic                to_expire;
    logic [N_STICKY-1:0] sticky_set, sticky_q;
    logic                the_q, the_cond;
    logic                ti_q, tfe_q, tff_q;
    xfer_mode_e          mode;

    uart_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(cts_n), .sync_o(cts_sync));

    uart_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_dsr_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(dsr_n), .sync_o(dsr_sync));

    uart_rx_timeout #(
        .WL_CODE_W(2), .WL_BASE(WL_BASE), .TO_MUL(TO_MUL), .TO_ADD(TO_ADD)
    ) u_rx_timeout (
        .clk(clk), .rst_n(rst_n), .word_len(cfg_word_len), .unit_tick(unit_tick),
        .rx_has_data(rx_has_data), .rx_push(rx_push), .rx_pop(rx_pop),
        .expire_o(to_expire));

    // CTS edge detection after the synchronizer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cts_prev_q <= 1'b1;
        else        cts_prev_q <= cts_sync;
    end
    assign cts_change = cts_sync ^ cts_prev_q;

    always_comb begin
        sticky_set           = '0;
        sticky_set[ST_RXTO]  = to_expire;
        sticky_set[ST_ABD]   = autobaud_done;
        sticky_set[ST_CTSEV] = cts_change;
    end

    // sticky bits: a set beats a write-one clear
    for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        sticky_q[i] <= 1'b0;
            else if (sticky_set[i])            sticky_q[i] <= 1'b1;
            else if (clr_wr && clr_mask[i])    sticky_q[i] <= 1'b0;
        end
    end

    // transmit holding empty: a data write beats the set
    assign the_cond = cfg_fifo_mode ? (tx_fifo_level <= tx_fifo_trig) : tx_hold_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            the_q <= 1'b1;
            ti_q  <= 1'b1;
            tfe_q <= 1'b1;
            tff_q <= 1'b0;
        end else begin
            if (tx_write)      the_q <= 1'b0;
            else if (the_cond) the_q <= 1'b1;
            ti_q  <= tx_shift_empty && (cfg_fifo_mode ? tx_fifo_empty : tx_hold_empty);
            tfe_q <= tx_fifo_empty;
            tff_q <= tx_fifo_full;
        end
    end

    always_comb begin
        status           = '0;
        status[ST_RXTO]  = sticky_q[ST_RXTO];
        status[ST_ABD]   = sticky_q[ST_ABD];
        status[ST_CTSEV] = sticky_q[ST_CTSEV];
        status[ST_THE]   = the_q;
        status[ST_TI]    = ti_q;
        status[ST_TFE]   = tfe_q;
        status[ST_TFF]   = tff_q;
        status[ST_CTS]   = ~cts_sync;
        status[ST_DSR]   = ~dsr_sync;
    end

    assign mode    = xfer_mode_e'(cfg_xfer_mode);
    assign irq     = (|(sticky_q & int_en[N_STICKY-1:0]))
                   | ((mode == XM_IRQ) && the_q && int_en[ST_THE]);
    assign dma_req = the_q && ((mode == XM_DMA_A) || (mode == XM_DMA_B));

    // R4: a set timeout bit persists without a matching clear
    a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_RXTO] && !(clr_wr && clr_mask[ST_RXTO])) |=> status[ST_RXTO]);

    // R6: a change of the mirrored CTS level is followed by the event bit
    a_r6_cts_change_event: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status[ST_CTS]) |=> status[ST_CTSEV]);

    // R7: a busy shift register means the transmitter is not idle
    a_r7_busy_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_shift_empty |=> !status[ST_TI]);

    // R8: a data write clears transmit holding empty
    a_r8_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        tx_write |=> !status[ST_THE]);

    // R9: no enables, no interrupt
    a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en == '0) |-> !irq);

    // R10: no DMA request outside the DMA modes
    a_r10_no_dma: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_xfer_mode[1] |-> !dma_req);

    // R12: reserved bits stay zero
    a_r12_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(status[STAT_W-1:USED_BITS]) == 0);
endmodule

// File: tb/uart_stat_irq_bench.sv
module uart_stat_irq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_word_len = 2'd0;
    logic        cfg_fifo_mode = 1'b0;
    logic [1:0]  cfg_xfer_mode = 2'b00;
    logic [3:0]  int_en = 4'b0;
    logic        clr_wr = 1'b0;
    logic [2:0]  clr_mask = 3'b0;
    logic        unit_tick = 1'b0;
    logic        rx_has_data = 1'b0;
    logic        rx_push = 1'b0;
    logic        rx_pop = 1'b0;
    logic        autobaud_done = 1'b0;
    logic        cts_n = 1'b1;
    logic        dsr_n = 1'b1;
    logic        tx_hold_empty = 1'b1;
    logic        tx_shift_empty = 1'b1;
    logic        tx_fifo_empty = 1'b1;
    logic        tx_fifo_full = 1'b0;
    logic [4:0]  tx_fifo_level = 5'd0;
    logic [4:0]  tx_fifo_trig = 5'd0;
    logic        tx_write = 1'b0;
    logic [15:0] status;
    logic        irq, dma_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    uart_stat_irq u_uart_stat_irq (
        .clk(clk), .rst_n(rst_n), .cfg_word_len(cfg_word_len),
        .cfg_fifo_mode(cfg_fifo_mode), .cfg_xfer_mode(cfg_xfer_mode),
        .int_en(int_en), .clr_wr(clr_wr), .clr_mask(clr_mask),
        .unit_tick(unit_tick), .rx_has_data(rx_has_data), .rx_push(rx_push),
        .rx_pop(rx_pop), .autobaud_done(autobaud_done), .cts_n(cts_n),
        .dsr_n(dsr_n), .tx_hold_empty(tx_hold_empty),
        .tx_shift_empty(tx_shift_empty), .tx_fifo_empty(tx_fifo_empty),
        .tx_fifo_full(tx_fifo_full), .tx_fifo_level(tx_fifo_level),
        .tx_fifo_trig(tx_fifo_trig), .tx_write(tx_write),
        .status(status), .irq(irq), .dma_req(dma_req));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_sticky(input logic [2:0] m);
        clr_wr = 1'b1; clr_mask = m;
        step(1);
        clr_wr = 1'b0; clr_mask = 3'b0;
    endtask

    task automatic t_reset;
        step(1);
        check("R1 status", status, 32'h38);
        check("R1 irq", irq, 0);
        check("R1 dma", dma_req, 0);
    endtask

    task automatic t_timeout_basic(input logic [1:0] code);
        int lim;
        lim = (5 + int'(code)) * 4 + 12;
        cfg_word_len = code;
        rx_has_data = 1'b1; rx_push = 1'b1;
        step(1);
        rx_push = 1'b0; unit_tick = 1'b1;
        step(lim - 1);
        check("R2 not before limit", status[0], 0);
        step(1);
        check("R2 at limit", status[0], 1);
        unit_tick = 1'b0; rx_has_data = 1'b0;
        clear_sticky(3'b001);
        check("R4 cleared", status[0], 0);
    endtask

    task automatic t_timeout_restart;
        int lim;
        lim = 5 * 4 + 12;
        cfg_word_len = 2'd0;
        rx_has_data = 1'b1; rx_push = 1'b1;
        step(1);
        rx_push = 1'b0; unit_tick = 1'b1;
        step(20);
        unit_tick = 1'b0; rx_pop = 1'b1;
        step(1);
        rx_pop = 1'b0; unit_tick = 1'b1;
        step(lim - 1);
        check("R3 restart on pop", status[0], 0);
        step(1);
        check("R3 fires after restart", status[0], 1);
        int_en = 4'b0001;
        step(1);
        check("R9 irq from timeout", irq, 1);
        int_en = 4'b0000;
        step(1);
        check("R9 irq masked", irq, 0);
        unit_tick = 1'b0; rx_has_data = 1'b0;
        clear_sticky(3'b001);
        rx_has_data = 1'b0; unit_tick = 1'b1;
        step(100);
        check("R3 empty no timeout", status[0], 0);
        unit_tick = 1'b0;
    endtask

    task automatic t_sticky;
        autobaud_done = 1'b1;
        step(1);
        autobaud_done = 1'b0;
        check("R4 autobaud set", status[1], 1);
        clr_wr = 1'b1; clr_mask = 3'b101;
        step(1);
        clr_wr = 1'b0; clr_mask = 3'b0;
        check("R4 mask 0 keeps", status[1], 1);
        autobaud_done = 1'b1; clr_wr = 1'b1; clr_mask = 3'b010;
        step(1);
        autobaud_done = 1'b0; clr_wr = 1'b0; clr_mask = 3'b0;
        check("R4 set wins", status[1], 1);
        clear_sticky(3'b010);
        check("R4 clear", status[1], 0);
    endtask

    task automatic t_modem;
        int_en = 4'b0100;
        cts_n = 1'b0; dsr_n = 1'b0;
        step(1);
        check("R5 cts not yet", status[7], 0);
        step(1);
        check("R5 cts mirror", status[7], 1);
        check("R5 dsr mirror", status[8], 1);
        check("R6 event not yet", status[2], 0);
        step(1);
        check("R6 event fall", status[2], 1);
        check("R9 irq cts", irq, 1);
        clear_sticky(3'b100);
        step(3);
        check("R6 single event", status[2], 0);
        cts_n = 1'b1;
        step(3);
        check("R6 event rise", status[2], 1);
        check("R5 cts released", status[7], 0);
        clear_sticky(3'b100);
        dsr_n = 1'b1;
        step(2);
        check("R5 dsr released", status[8], 0);
        check("R6 dsr no event", status[2], 0);
        int_en = 4'b0;
    endtask

    task automatic t_tx_idle;
        tx_shift_empty = 1'b0;
        step(1);
        check("R7 shift busy", status[4], 0);
        tx_shift_empty = 1'b1; tx_hold_empty = 1'b0;
        step(1);
        check("R7 hold busy", status[4], 0);
        cfg_fifo_mode = 1'b1; tx_fifo_empty = 1'b1;
        step(1);
        check("R7 fifo mode idle", status[4], 1);
        tx_fifo_empty = 1'b0;
        step(1);
        check("R7 fifo not empty", status[4], 0);
        check("R11 fifo empty flag", status[5], 0);
        tx_fifo_full = 1'b1;
        step(1);
        check("R11 fifo full flag", status[6], 1);
        check("R12 reserved", status[15:9], 0);
        tx_fifo_full = 1'b0; tx_fifo_empty = 1'b1; tx_hold_empty = 1'b1;
        cfg_fifo_mode = 1'b0;
        step(1);
        check("R11 flags back", status[6:5], 2'b01);
    endtask

    task automatic t_the;
        cfg_fifo_mode = 1'b0; tx_hold_empty = 1'b0; tx_write = 1'b1;
        step(1);
        tx_write = 1'b0;
        check("R8 write clears", status[3], 0);
        step(2);
        check("R8 stays clear", status[3], 0);
        tx_hold_empty = 1'b1;
        step(1);
        check("R8 nonfifo set", status[3], 1);
        cfg_fifo_mode = 1'b1; tx_fifo_level = 5'd5; tx_fifo_trig = 5'd2; tx_write = 1'b1;
        step(1);
        tx_write = 1'b0;
        check("R8 fifo write clears", status[3], 0);
        step(1);
        check("R8 above trigger", status[3], 0);
        tx_fifo_level = 5'd2;
        step(1);
        check("R8 at trigger", status[3], 1);
        tx_fifo_level = 5'd0; cfg_fifo_mode = 1'b0;
    endtask

    task automatic t_routing;
        cfg_xfer_mode = 2'b01; int_en = 4'b1000;
        step(1);
        check("R9 the irq", irq, 1);
        check("R10 no dma in 01", dma_req, 0);
        int_en = 4'b0000;
        step(1);
        check("R9 the irq masked", irq, 0);
        int_en = 4'b1000; cfg_xfer_mode = 2'b10;
        step(1);
        check("R10 dma 10", dma_req, 1);
        check("R10 no irq 10", irq, 0);
        cfg_xfer_mode = 2'b11;
        step(1);
        check("R10 dma 11", dma_req, 1);
        cfg_xfer_mode = 2'b00;
        step(1);
        check("R10 off dma", dma_req, 0);
        check("R9 off irq", irq, 0);
        int_en = 4'b0;
    endtask

    initial begin
        step(2);
        rst_n = 1'b1;
        t_reset();
        t_timeout_basic(2'd0);
        t_timeout_basic(2'd3);
        t_timeout_restart();
        t_sticky();
        t_modem();
        t_tx_idle();
        t_the();
        t_routing();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule